// File: doc/BRIEF.md
# SPI Serial Clock Rate Generator

This block derives the serial clock of an SPI controller from the module clock. The period of the serial clock is the product of two factors. A 2-bit code picks a small prime factor (2, 3, 5 or 7). A 4-bit code picks a larger factor from a ladder that counts up 2, 4, 6, 8 and then doubles up to 32768. The clock thus covers a wide range of rates with fine steps at the fast end.

The generator drives the serial clock level itself. It also drives two single-cycle strobes for the shift logic around it. The edge strobe marks every cycle in which the clock changes level. The period strobe marks the last module clock of each full period. While the enable is low, the clock rests at the level chosen by the polarity input and the period count restarts. A code change made during a period is held off until the next period begins, so the clock never shows a shortened pulse. The polarity input is static configuration and is changed only while the block is disabled.

Top module: `sck_rate_gen`

## Requirements
- R1: The 2-bit prescale code selects a factor of 2, 3, 5 or 7 for code values 0, 1, 2 and 3.
- R2: The 4-bit scale code selects a factor of 2, 4, 6 or 8 for code values 0 to 3. For a code value c of 4 or more it selects 2 to the power c (16 up to 32768).
- R3: While enabled, one serial clock period lasts P module clocks, where P is the product of the two factors. The clock sits at the non-idle level for the first ceil(P/2) cycles and at the idle level for the remaining floor(P/2) cycles.
- R4: While enable is low, sck equals cpol and neither strobe pulses. The first enabled clock edge after a low enable starts a fresh period at its first cycle.
- R5: half_tick is high for exactly the one cycle in which sck has just changed level during enabled operation. It pulses at both the start of a period and the midpoint of the period.
- R6: full_tick is high for one cycle, the last cycle of each period, and is never high together with half_tick. If enable stays high, half_tick follows it in the next cycle.
- R7: A code change that takes place during a period does not alter that period. The codes present on the clock edge that starts a period set that period's length.
- R8: The idle level of sck is cpol, and the non-idle level is the inverse of cpol.
- R9: During reset and after it, sck equals cpol and both strobes are low until the block is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Runs the generator when high; holds it idle when low |
| pre_code | input | 2 | Prescale factor select (2, 3, 5, 7) |
| scl_code | input | 4 | Scale factor select (2, 4, 6, 8, then powers of two) |
| cpol | input | 1 | Idle level of the serial clock |
| half_tick | output | 1 | One-cycle strobe in the cycle of each sck level change |
| full_tick | output | 1 | One-cycle strobe in the last cycle of each period |
| sck | output | 1 | Serial clock level |

## Verification
Two events can land on the same clock edge: a code change and a period boundary. The result decides which length the next period takes. The bench changes the codes on the cycle just before a boundary edge and also on the boundary cycle itself. It also changes them at random points within periods. A cycle-accurate bench model loads the codes only when its own position returns to zero and compares sck and both strobes on every cycle. A drop of enable that comes together with a period strobe is also provoked. The bench then judges that the next run begins with a full first half period.

// File: rtl/sck_div_pkg.sv
package sck_div_pkg;
  localparam int PRE_W   = 2;
  localparam int SCL_W   = 4;
  localparam int PRE_MAX = 7;
  localparam int SCL_MAX = 2 ** (2 ** SCL_W - 1);
  localparam int DIV_W   = $clog2(PRE_MAX * SCL_MAX + 1);

  typedef logic [DIV_W-1:0] div_t;

  // Prime prescale factor for each 2-bit code.
  function automatic div_t pre_factor(input logic [PRE_W-1:0] code);
    div_t f;
    unique case (code)
      2'd0:    f = div_t'(2);
      2'd1:    f = div_t'(3);
      2'd2:    f = div_t'(5);
      default: f = div_t'(7);
    endcase
    return f;
  endfunction

  // Scale factor: linear 2..8 for the low codes, then 2^code.
  function automatic div_t scl_factor(input logic [SCL_W-1:0] code);
    div_t f;
    if (code < SCL_W'(4)) f = div_t'({code, 1'b0}) + div_t'(2);
    else                  f = div_t'(1) << code;
    return f;
  endfunction
endpackage

// File: rtl/sck_reset_sync.sv
module sck_reset_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/sck_ratio_select.sv
module sck_ratio_select
  import sck_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             at_start,
  input  logic [PRE_W-1:0] pre_code,
  input  logic [SCL_W-1:0] scl_code,
  output div_t             period,
  output div_t             active_len
);
  div_t req_period;
  div_t held_q;
  div_t held_d;

  // Requested period comes straight from the codes; it is used only at a
  // period start and held for the rest of that period.
  always_comb begin
    req_period = pre_factor(pre_code) * scl_factor(scl_code);
    period     = at_start ? req_period : held_q;
    active_len = (period + div_t'(1)) >> 1;
  end

  always_comb begin
    held_d = held_q;
    if (enable) held_d = period;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end
endmodule

// File: rtl/sck_phase_counter.sv
module sck_phase_counter
  import sck_div_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  div_t period,
  output div_t cnt,
  output logic at_start,
  output logic at_last
);
  div_t cnt_q;
  div_t cnt_d;

  always_comb begin
    at_start = (cnt_q == '0);
    at_last  = (cnt_q == period - div_t'(1));
  end

  always_comb begin
    if (!enable)      cnt_d = '0;
    else if (at_last) cnt_d = '0;
    else              cnt_d = cnt_q + div_t'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/sck_edge_gen.sv
module sck_edge_gen
  import sck_div_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  div_t cnt,
  input  logic at_start,
  input  logic at_last,
  input  div_t active_len,
  output logic active,
  output logic half_tick,
  output logic full_tick
);
  logic act_q, act_d;
  logic half_q, half_d;
  logic full_q, full_d;

  always_comb begin
    act_d  = enable && (cnt < active_len);
    half_d = enable && (at_start || (cnt == active_len));
    full_d = enable && at_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      half_q <= 1'b0;
      full_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      half_q <= half_d;
      full_q <= full_d;
    end
  end

  assign active    = act_q;
  assign half_tick = half_q;
  assign full_tick = full_q;
endmodule

// File: rtl/sck_rate_gen.sv
module sck_rate_gen
  import sck_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [PRE_W-1:0] pre_code,
  input  logic [SCL_W-1:0] scl_code,
  input  logic             cpol,
  output logic             half_tick,
  output logic             full_tick,
  output logic             sck
);
  logic rst_n_int;
  logic at_start;
  logic at_last;
  logic active;
  div_t period;
  div_t active_len;
  div_t cnt;

  sck_reset_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_int)
  );

  sck_ratio_select u_ratio (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .enable     (enable),
    .at_start   (at_start),
    .pre_code   (pre_code),
    .scl_code   (scl_code),
    .period     (period),
    .active_len (active_len)
  );

  sck_phase_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .enable   (enable),
    .period   (period),
    .cnt      (cnt),
    .at_start (at_start),
    .at_last  (at_last)
  );

  sck_edge_gen u_edge (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .enable     (enable),
    .cnt        (cnt),
    .at_start   (at_start),
    .at_last    (at_last),
    .active_len (active_len),
    .active     (active),
    .half_tick  (half_tick),
    .full_tick  (full_tick)
  );

  // Polarity only flips the presented level; the phase logic is polarity-free.
  assign sck = cpol ^ active;
endmodule

// File: rtl/sck_rate_gen_chk.sv
module sck_rate_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic cpol,
  input logic half_tick,
  input logic full_tick,
  input logic sck
);
  assert_idle_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!half_tick && !full_tick && (sck == cpol)));

  assert_tick_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick && (cpol == $past(cpol))) |-> (sck != $past(sck)));

  assert_edge_has_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && (sck != $past(sck)) && (cpol == $past(cpol))) |-> half_tick);

  assert_half_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |=> !half_tick);

  assert_ticks_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({half_tick, full_tick}));

  assert_wrap_restarts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (full_tick && enable) |=> half_tick);
endmodule

bind sck_rate_gen sck_rate_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .cpol      (cpol),
  .half_tick (half_tick),
  .full_tick (full_tick),
  .sck       (sck)
);

// File: tb/tb_sck_rate_gen.sv
`timescale 1ns/1ps
module tb_sck_rate_gen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable;
  logic [1:0] pre_code;
  logic [3:0] scl_code;
  logic       cpol;
  logic       half_tick;
  logic       full_tick;
  logic       sck;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sck_rate_gen dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pre_code(pre_code),
    .scl_code(scl_code), .cpol(cpol), .half_tick(half_tick),
    .full_tick(full_tick), .sck(sck)
  );

  function automatic int b_pre(input int c);
    int t[4] = '{2, 3, 5, 7};
    return t[c];
  endfunction

  function automatic int b_scl(input int c);
    int t[16] = '{2, 4, 6, 8, 16, 32, 64, 128, 256, 512, 1024, 2048,
                  4096, 8192, 16384, 32768};
    return t[c];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Runs the generator for ncyc cycles and compares every cycle against a
  // model built from R1..R8. At iteration chg_at the codes switch.
  task automatic run_seq(input int pc, input int sc, input bit cp,
                         input int ncyc, input int chg_at,
                         input int pc2, input int sc2, input string req);
    int pos = 0;
    int p = 0;
    int a = 0;
    int bad[3] = '{0, 0, 0};
    int fa[3]  = '{0, 0, 0};
    int fe[3]  = '{0, 0, 0};
    bit e_act, e_half, e_full;
    pre_code = 2'(pc); scl_code = 4'(sc); cpol = cp; enable = 1'b1;
    for (int k = 0; k < ncyc; k++) begin
      if (pos == 0) begin
        p = b_pre(int'(pre_code)) * b_scl(int'(scl_code));
        a = (p + 1) / 2;
      end
      e_act  = (pos < a);
      e_half = (pos == 0) || (pos == a);
      e_full = (pos == p - 1);
      pos = (pos == p - 1) ? 0 : pos + 1;
      @(negedge clk);
      if (sck !== (cp ^ e_act)) begin
        if (bad[0] == 0) begin fa[0] = int'(sck); fe[0] = int'(cp ^ e_act); end
        bad[0]++;
      end
      if (half_tick !== e_half) begin
        if (bad[1] == 0) begin fa[1] = int'(half_tick); fe[1] = int'(e_half); end
        bad[1]++;
      end
      if (full_tick !== e_full) begin
        if (bad[2] == 0) begin fa[2] = int'(full_tick); fe[2] = int'(e_full); end
        bad[2]++;
      end
      if (k == chg_at) begin pre_code = 2'(pc2); scl_code = 4'(sc2); end
    end
    enable = 1'b0;
    check(bad[0] == 0, req, "sck level per cycle", fa[0], fe[0]);
    check(bad[1] == 0, {req, " R5"}, "half_tick per cycle", fa[1], fe[1]);
    check(bad[2] == 0, {req, " R6"}, "full_tick per cycle", fa[2], fe[2]);
  endtask

  // R4: disabled for n cycles with codes moving; sck idles, no strobes.
  task automatic idle_check(input int n);
    int bad = 0;
    int av = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (sck !== cpol || half_tick !== 1'b0 || full_tick !== 1'b0) begin
        if (bad == 0) av = int'({sck, half_tick, full_tick});
        bad++;
      end
      pre_code = 2'($urandom % 4); scl_code = 4'($urandom % 16);
    end
    check(bad == 0, "R4", "idle {sck,half,full}", av, int'({cpol, 2'b00}));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int pc, sc, pc2, sc2, p, n;
    bit cp;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; enable = 1'b0; pre_code = 2'd0; scl_code = 4'd0; cpol = 1'b1;
    repeat (3) @(negedge clk);
    check(sck === 1'b1 && half_tick === 1'b0 && full_tick === 1'b0, "R9",
          "reset {sck,half,full}", int'({sck, half_tick, full_tick}), 4);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(sck === 1'b1 && half_tick === 1'b0 && full_tick === 1'b0, "R9",
          "after reset {sck,half,full}", int'({sck, half_tick, full_tick}), 4);

    // R1 each prescale value with the smallest scale, both polarities (R8).
    for (int c = 0; c < 4; c++) begin
      run_seq(c, 0, c[0], 3 * b_pre(c) * 2, -1, 0, 0, "R1 R3 R8");
      idle_check(2);
    end
    // R2 the linear and doubling sections of the scale ladder.
    for (int c = 0; c < 7; c++) begin
      run_seq(1, c, 1'b0, 2 * 3 * b_scl(c) + 3, -1, 0, 0, "R2 R3");
      idle_check(2);
    end
    // R2 top code: one full period of 65536 cycles plus the restart.
    run_seq(0, 15, 1'b1, 65536 + 4, -1, 0, 0, "R2 R3");
    idle_check(3);

    // R7: change mid-period, on the boundary-driving cycle, and on the boundary.
    run_seq(3, 8, 1'b0, 1792 + 60, 100, 1, 0, "R7");
    idle_check(2);
    run_seq(2, 1, 1'b0, 20 + 30, 19, 0, 2, "R7");
    idle_check(2);
    run_seq(2, 1, 1'b1, 20 + 30, 20, 0, 2, "R7");
    idle_check(2);

    // R4: stop in mid-period, then restart fresh; stop on a full tick.
    run_seq(3, 2, 1'b0, 22, -1, 0, 0, "R4");
    idle_check(1);
    run_seq(3, 2, 1'b0, 42, -1, 0, 0, "R4");
    idle_check(2);
    run_seq(0, 1, 1'b0, 24, -1, 0, 0, "R4");

    // Random configurations with random code changes.
    for (int i = 0; i < 24; i++) begin
      pc = $urandom % 4; sc = $urandom % 6; cp = 1'($urandom % 2);
      pc2 = $urandom % 4; sc2 = $urandom % 6;
      p = b_pre(pc) * b_scl(sc);
      n = 2 * p + int'($urandom % p);
      run_seq(pc, sc, cp, n, int'($urandom % n), pc2, sc2, "R3 R7");
      idle_check(1 + int'($urandom % 3));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule